// File: doc/BRIEF.md
# Four-Thread Fetch Unit with Held-Word Buffers

This unit feeds the decode stage of a scalar core that interleaves four hardware threads. Each thread owns a fetch program counter and a one-entry holding register. Every cycle an outside scheduler names one thread. The unit then sends exactly one instruction of that thread down the pipe, tagged with the thread number and the instruction's address.

Instruction memory is read as two-word lines through one port that all threads share. The port returns both words in the same cycle as the request. When a thread's fetch address is even, the whole line is useful. The lower word issues at once and the upper word waits in the thread's holding register. The next time that thread is picked, the held word issues without touching memory. When the fetch address is odd, only the upper word of the line is used.

A redirect, from a taken branch or a trap, loads a new fetch address into one thread and throws away whatever that thread was holding.

Top module: `mt_fetch_unit`

## Requirements
- R1: After reset, `out_valid` is 0, every holding register is empty, and the first fetch of every thread reads from `RESET_VEC`.
- R2: When the chosen thread's holding register is empty and its fetch address A is even, the unit does the following. It raises `imem_req` with `imem_addr` = A. One cycle later it issues the lower word (`imem_rdata_lo`) with `out_pc` = A. It stores the upper word and advances the fetch address to A+2.
- R3: When the chosen thread's holding register is full, the unit does the following. It keeps `imem_req` low. One cycle later it issues the held word, with `out_pc` one below the fetch address. It then empties the register and leaves the fetch address unchanged.
- R4: When the chosen thread's fetch address A is odd, the unit does the following. It requests line A-1, which is `imem_addr` with bit 0 cleared. It issues the upper word (`imem_rdata_hi`) with `out_pc` = A. It advances the fetch address to A+1 and stores nothing.
- R5: At most one instruction issues per cycle. `out_valid` in cycle n+1 is 1 exactly when a thread was chosen in cycle n and that choice was not cancelled. `imem_req` is never high unless `sel_valid` is high.
- R6: Fetch addresses and holding registers are private to each thread. Activity on one thread never changes what another thread issues next.
- R7: A redirect for thread T loads T's fetch address with `redir_pc` and empties T's holding register. This happens whether or not T is chosen, and it takes effect for the next selection of T.
- R8: If the chosen thread is also the thread being redirected in the same cycle, nothing issues and `imem_req` stays low.
- R9: `out_tid` equals the `sel_tid` of the cycle that produced the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | A thread is chosen this cycle |
| sel_tid | input | 2 | Chosen thread |
| redir_valid | input | 1 | Redirect request |
| redir_tid | input | 2 | Thread being redirected |
| redir_pc | input | 16 | New fetch word address |
| imem_req | output | 1 | Memory line read this cycle |
| imem_addr | output | 16 | Even word address of the line |
| imem_rdata_lo | input | 32 | Word at `imem_addr` (same cycle) |
| imem_rdata_hi | input | 32 | Word at `imem_addr`+1 (same cycle) |
| out_valid | output | 1 | Instruction valid to decode |
| out_tid | output | 2 | Owning thread |
| out_pc | output | 16 | Word address of the instruction |
| out_insn | output | 32 | Instruction word |

## Verification
The bench targets the following corner cases:
- A held word issued after other threads have run in between. A design with shared holding state would issue another thread's word.
- A thread redirected while its holding register is full. A design that did not flush it would issue a stale word instead of fetching the target.
- An odd redirect target. A design that handled it wrongly would issue the lower word or park a word that does not belong.
- A redirect that collides with selection of the same thread. A design that did not cancel would emit an instruction from the abandoned path.

A random phase mixes all of these under a behavioural model and compares the outputs every cycle.

// File: rtl/mt_fetch_unit.sv
module mt_fetch_unit #(
  parameter int NT = 4,
  parameter int AW = 16,
  parameter int IW = 32,
  parameter logic [AW-1:0] RESET_VEC = 16'h0100,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_valid,
  input  logic [TW-1:0] sel_tid,
  input  logic          redir_valid,
  input  logic [TW-1:0] redir_tid,
  input  logic [AW-1:0] redir_pc,
  output logic          imem_req,
  output logic [AW-1:0] imem_addr,
  input  logic [IW-1:0] imem_rdata_lo,
  input  logic [IW-1:0] imem_rdata_hi,
  output logic          out_valid,
  output logic [TW-1:0] out_tid,
  output logic [AW-1:0] out_pc,
  output logic [IW-1:0] out_insn
);
  logic [AW-1:0] pc_q  [NT];
  logic [IW-1:0] hold_q[NT];
  logic [NT-1:0] held_q;

  wire           cancel = redir_valid && (redir_tid == sel_tid);
  wire           go     = sel_valid && !cancel;
  wire           hit    = held_q[sel_tid];
  wire [AW-1:0]  cur_pc = pc_q[sel_tid];

  assign imem_req  = go && !hit;
  assign imem_addr = {cur_pc[AW-1:1], 1'b0};

  for (genvar t = 0; t < NT; t++) begin : g_thr
    wire mine = go && (sel_tid == TW'(t));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pc_q[t]   <= RESET_VEC;
        held_q[t] <= 1'b0;
        hold_q[t] <= '0;
      end else if (redir_valid && redir_tid == TW'(t)) begin
        pc_q[t]   <= redir_pc;
        held_q[t] <= 1'b0;
      end else if (mine) begin
        if (held_q[t]) begin
          held_q[t] <= 1'b0;
        end else if (!pc_q[t][0]) begin
          pc_q[t]   <= pc_q[t] + AW'(2);
          held_q[t] <= 1'b1;
          hold_q[t] <= imem_rdata_hi;
        end else begin
          pc_q[t]   <= pc_q[t] + AW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tid   <= '0;
      out_pc    <= '0;
      out_insn  <= '0;
    end else begin
      out_valid <= go;
      if (go) begin
        out_tid  <= sel_tid;
        out_pc   <= hit ? cur_pc - AW'(1) : cur_pc;
        out_insn <= hit ? hold_q[sel_tid] : (cur_pc[0] ? imem_rdata_hi : imem_rdata_lo);
      end
    end
  end
endmodule

// File: rtl/mt_fetch_unit_chk.sv
module mt_fetch_unit_chk #(
  parameter int NT = 4,
  parameter int AW = 16,
  parameter int IW = 32,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_valid,
  input logic [TW-1:0] sel_tid,
  input logic          redir_valid,
  input logic [TW-1:0] redir_tid,
  input logic          imem_req,
  input logic [AW-1:0] imem_addr,
  input logic          out_valid,
  input logic [TW-1:0] out_tid
);
  wire clash = redir_valid && sel_valid && (redir_tid == sel_tid);

  p_req_needs_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |-> sel_valid);
  p_issue_follows_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !clash) |=> out_valid);
  p_idle_no_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> !out_valid);
  p_line_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req |-> !imem_addr[0]);
  p_clash_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (!imem_req ##1 !out_valid));
  p_tid_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !clash) |=> (out_tid == $past(sel_tid)));
endmodule

bind mt_fetch_unit mt_fetch_unit_chk #(.NT(NT), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_tid(sel_tid),
  .redir_valid(redir_valid), .redir_tid(redir_tid), .imem_req(imem_req),
  .imem_addr(imem_addr), .out_valid(out_valid), .out_tid(out_tid));

// File: tb/mt_fetch_unit_test.sv
module mt_fetch_unit_test;
  localparam logic [15:0] RV = 16'h0100;
  logic clk = 0, rst_n = 0;
  logic sel_valid = 0, redir_valid = 0;
  logic [1:0] sel_tid = 0, redir_tid = 0;
  logic [15:0] redir_pc = 0, imem_addr, out_pc;
  logic imem_req, out_valid;
  logic [31:0] lo, hi, out_insn;
  logic [1:0] out_tid;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] mem(input logic [15:0] a);
    return 32'hC0DE_0000 ^ (32'(a) * 32'h0000_9E37);
  endfunction
  assign lo = mem(imem_addr);
  assign hi = mem(imem_addr + 16'd1);

  mt_fetch_unit #(.RESET_VEC(RV)) uut (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_tid(sel_tid),
    .redir_valid(redir_valid), .redir_tid(redir_tid), .redir_pc(redir_pc),
    .imem_req(imem_req), .imem_addr(imem_addr), .imem_rdata_lo(lo),
    .imem_rdata_hi(hi), .out_valid(out_valid), .out_tid(out_tid),
    .out_pc(out_pc), .out_insn(out_insn));

  // behavioural model
  logic [15:0] m_pc[4];
  bit          m_bv[4];
  logic [31:0] m_bi[4];
  bit          e_v;
  logic [1:0]  e_tid;
  logic [15:0] e_pc;
  logic [31:0] e_insn;
  string       e_req;
  bit          pend = 0;

  task automatic chk(input bit ok, input string rq, input string act, input string exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", rq, act, exp);
    end
  endtask

  task automatic check_out();
    if (!pend) return;
    if (!e_v)
      chk(out_valid == 0, e_req, $sformatf("v=%0b", out_valid), "v=0");
    else
      chk(out_valid && out_tid == e_tid && out_pc == e_pc && out_insn == e_insn,
          {e_req, "/R9"},
          $sformatf("v=%0b t=%0d pc=%h i=%h", out_valid, out_tid, out_pc, out_insn),
          $sformatf("v=1 t=%0d pc=%h i=%h", e_tid, e_pc, e_insn));
  endtask

  task automatic step(input bit sv, input logic [1:0] st, input bit rv,
                      input logic [1:0] rt, input logic [15:0] rp, input string tag = "");
    bit cancel, xreq;
    logic [15:0] xaddr;
    @(negedge clk);
    check_out();
    sel_valid = sv; sel_tid = st; redir_valid = rv; redir_tid = rt; redir_pc = rp;
    #1;
    cancel = rv && sv && (rt == st);
    xreq = sv && !cancel && !m_bv[st];
    xaddr = m_pc[st] & 16'hFFFE;
    if (xreq)
      chk(imem_req && imem_addr == xaddr, "R2/R4 request",
          $sformatf("req=%0b a=%h", imem_req, imem_addr), $sformatf("req=1 a=%h", xaddr));
    else
      chk(!imem_req, cancel ? "R8 request" : "R3/R5 request",
          $sformatf("req=%0b", imem_req), "req=0");
    e_v = sv && !cancel; e_tid = st;
    e_req = tag != "" ? tag : (!sv ? "R5 idle" : cancel ? "R8 cancel" : m_bv[st] ? "R3 held" :
            m_pc[st][0] ? "R4 odd" : "R2 even");
    if (e_v) begin
      if (m_bv[st]) begin
        e_pc = m_pc[st] - 16'd1; e_insn = m_bi[st]; m_bv[st] = 0;
      end else if (!m_pc[st][0]) begin
        e_pc = m_pc[st]; e_insn = mem(m_pc[st]);
        m_bv[st] = 1; m_bi[st] = mem(m_pc[st] + 16'd1); m_pc[st] += 16'd2;
      end else begin
        e_pc = m_pc[st]; e_insn = mem(m_pc[st]); m_pc[st] += 16'd1;
      end
    end
    if (rv) begin m_pc[rt] = rp; m_bv[rt] = 0; end
    pend = 1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_pc[i] = RV; m_bv[i] = 0; m_bi[i] = 0; end
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 reset", $sformatf("v=%0b", out_valid), "v=0");
    rst_n = 1;
    // R1: each thread starts at the reset vector
    for (int t = 0; t < 4; t++) step(1, 2'(t), 0, 0, 0, "R1 first fetch");
    // R3 held words, interleaved across threads (R6)
    for (int t = 3; t >= 0; t--) step(1, 2'(t), 0, 0, 0, "R6 private hold");
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    // R4 odd target via redirect of unselected thread (R7)
    step(1, 2, 1, 1, 16'h0201);
    step(1, 1, 0, 0, 0, "R7 odd target");
    step(1, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    // R7 flush: thread 3 full, then redirected
    step(1, 3, 0, 0, 0);
    step(0, 0, 1, 3, 16'h0040);
    step(1, 3, 0, 0, 0, "R7 flush");
    step(1, 3, 0, 0, 0);
    // R8 clash
    step(1, 2, 1, 2, 16'h0300);
    step(1, 2, 0, 0, 0, "R7 after clash");
    step(0, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 15);
      step(r != 0, 2'($urandom), r < 3, 2'($urandom), 16'($urandom));
    end
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check_out();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule